// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit lets a small microcontroller core pull constant data out of its 16-bit-wide program memory. The core loads a two-part table pointer, an 8-bit offset and a 5-bit page number, through a small register port, then issues a read command. A regular command fetches the word at page:offset. A final-page command always fetches from the last 256-word page and uses only the offset, whatever the page register holds.

Each fetched word is split into two bytes. The low byte is written to the data memory location named in the command. The high byte goes into a dedicated latch, which the core can read back and also overwrite, so an interrupt routine can save and restore it. Basic commands always target data memory sector 0. Extended commands carry a sector number and write into that sector. The program memory is a synchronous ROM port: the word appears one cycle after the address is presented. Every command takes exactly two cycles.

Top module: `tblrd_unit`

## Requirements
- R1: After a synchronous active-low reset, the offset register, the page register and the high-byte latch all read 0, and `busy` and `dm_we` are low.
- R2: A regular command (`cmd_last`=0) fetches from `rom_addr` = {page[4:0], offset[7:0]}.
- R3: A final-page command (`cmd_last`=1) fetches from 0x1F00 + offset, whatever value the page register holds.
- R4: The low byte (bits 7:0) of the fetched word is driven on `dm_wdata`, and `dm_addr[7:0]` equals the `cmd_dest` given with the command.
- R5: The high byte (bits 15:8) of the fetched word is loaded into the high-byte latch. It can be read on `reg_rdata` with `reg_sel`=2 once the command finishes.
- R6: The core can write the high-byte latch with `reg_sel`=2 while the unit is idle, and the written value reads back unchanged.
- R7: A command accepted at a clock edge holds `busy` high for exactly the next two cycles. `rom_en` is high in the first of those cycles and `dm_we` is high in the second, for exactly one cycle each.
- R8: `dm_addr[9:8]` holds the sector. It is 0 for a basic command (`cmd_ext`=0) whatever `cmd_sector` holds, and equals `cmd_sector` for an extended command (`cmd_ext`=1).
- R9: A command presented while `busy` is high is ignored. No extra fetch or write follows, and `busy` is low in the cycle after the running command ends.
- R10: Register port writes (`reg_sel` 0 = offset, 1 = page, 2 = latch) that arrive while `busy` is high have no effect.
- R11: The page register keeps only its low 5 bits. Writing 0xFF reads back as 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 2 | Register select: 0 offset, 1 page, 2 high-byte latch |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register value (combinational) |
| cmd_valid | input | 1 | Start a table read |
| cmd_last | input | 1 | 1 = final-page read, 0 = regular read |
| cmd_ext | input | 1 | 1 = extended command using `cmd_sector` |
| cmd_sector | input | 2 | Destination sector for extended commands |
| cmd_dest | input | 8 | Destination address within the sector |
| busy | output | 1 | Command in progress |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 13 | ROM word address |
| rom_data | input | 16 | ROM word, valid the cycle after `rom_en` |
| dm_we | output | 1 | Data memory write strobe |
| dm_addr | output | 10 | Data memory address {sector, dest} |
| dm_wdata | output | 8 | Data memory write byte |

## Verification
The directed cases aim at the final-page read with a nonzero page register and offset 0x06, which must return the word at 0x1F06 with its zero high byte. A design that concatenated the page register there would fetch the wrong word, and one that skipped the latch would leave a stale high byte. A basic command with a nonzero sector field checks that only sector 0 is written. A design that passed the sector through would corrupt another bank. Commands and register writes are injected during both busy cycles: a unit that accepted them would show a third busy cycle, a second fetch or a changed pointer. Random traffic then mixes pointer values, modes, sectors and latch overwrites against bench-computed addresses and ROM contents.

// File: rtl/tblrd_pkg.sv
// Package: shared types and register-select codes for the table read unit.
// Assumes a 2-bit register select on the core-facing register port.
package tblrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } tr_state_e;

    localparam logic [1:0] RSEL_OFS   = 2'd0;
    localparam logic [1:0] RSEL_PAGE  = 2'd1;
    localparam logic [1:0] RSEL_LATCH = 2'd2;

endpackage

// File: rtl/tblrd_regs.sv
// Module: tblrd_regs
// Holds the table pointer (offset + page) and the high-byte latch, and
// drives the combinational register read mux.
// Assumes: core writes are honoured only when busy is low; the sequencer
// latch load (hi_we) never coincides with an idle-time core write.
module tblrd_regs
    import tblrd_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int PAGE_W = 5,
    parameter int HB_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [OFS_W-1:0]  wdata,
    input  logic              hi_we,
    input  logic [HB_W-1:0]   hi_data,
    output logic [OFS_W-1:0]  ptr_ofs,
    output logic [PAGE_W-1:0] ptr_page,
    output logic [OFS_W-1:0]  rdata
);

    localparam int PAD_PG = OFS_W - PAGE_W;

    logic [HB_W-1:0] hi_latch;
    logic            core_wr_ok;

    assign core_wr_ok = wr_en && !busy;

    // Purpose: pointer registers, written by the core while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_ofs  <= '0;
            ptr_page <= '0;
        end else if (core_wr_ok) begin
            if (sel == RSEL_OFS)  ptr_ofs  <= wdata;
            if (sel == RSEL_PAGE) ptr_page <= wdata[PAGE_W-1:0];
        end
    end

    // Purpose: high-byte latch, loaded by the sequencer or by the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_latch <= '0;
        end else if (hi_we) begin
            hi_latch <= hi_data;
        end else if (core_wr_ok && sel == RSEL_LATCH) begin
            hi_latch <= wdata[HB_W-1:0];
        end
    end

    // Purpose: register read mux for the core.
    always_comb begin
        rdata = '0;
        case (sel)
            RSEL_OFS:   rdata = ptr_ofs;
            RSEL_PAGE:  rdata = {{PAD_PG{1'b0}}, ptr_page};
            RSEL_LATCH: rdata = OFS_W'(hi_latch);
            default:    rdata = '0;
        endcase
    end

    AST_PTR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ptr_ofs) && $stable(ptr_page)))
        else $error("pointer changed while busy"); // R10

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> (hi_latch == $past(hi_data)))
        else $error("latch missed fetched high byte"); // R5

endmodule

// File: rtl/tblrd_addr.sv
// Module: tblrd_addr
// Forms the ROM fetch address from the pointer registers.
// Regular mode: {page, offset}. Final-page mode: all-ones page, offset.
// Assumes ADDR_W > OFS_W so that a page field exists.
module tblrd_addr #(
    parameter int ADDR_W = 13,
    parameter int OFS_W  = 8
) (
    input  logic [OFS_W-1:0]        ptr_ofs,
    input  logic [ADDR_W-OFS_W-1:0] ptr_page,
    input  logic                    last_page,
    output logic [ADDR_W-1:0]       fetch_addr
);

    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam logic [PAGE_W-1:0] LAST_PG = {PAGE_W{1'b1}};

    // Purpose: choose the page field according to the read mode.
    always_comb begin
        if (last_page) fetch_addr = {LAST_PG, ptr_ofs};
        else           fetch_addr = {ptr_page, ptr_ofs};
    end

endmodule

// File: rtl/tblrd_seq.sv
// Module: tblrd_seq
// Two-cycle read sequencer: cycle 1 drives the ROM address, cycle 2
// takes the ROM word and issues the data memory write and latch load.
// Assumes the ROM returns data one cycle after rom_en.
module tblrd_seq
    import tblrd_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DEST_W  = 8,
    parameter int SEC_W   = 2,
    parameter int DATA_W  = 16,
    parameter int LO_W    = 8,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic                    cmd_ext,
    input  logic [SEC_W-1:0]        cmd_sector,
    input  logic [DEST_W-1:0]       cmd_dest,
    input  logic [ADDR_W-1:0]       fetch_addr,
    input  logic [DATA_W-1:0]       rom_data,
    output logic                    busy,
    output logic                    accept,
    output logic                    rom_en,
    output logic [ADDR_W-1:0]       rom_addr,
    output logic                    dm_we,
    output logic [SEC_W+DEST_W-1:0] dm_addr,
    output logic [LO_W-1:0]         dm_wdata,
    output logic                    hi_we,
    output logic [DATA_W-LO_W-1:0]  hi_data
);

    tr_state_e          state;
    logic [ADDR_W-1:0]  addr_q;
    logic [DEST_W-1:0]  dest_q;
    logic [SEC_W-1:0]   sec_q;
    logic [SEC_W-1:0]   sec_sel;

    assign accept = cmd_valid && (state == ST_IDLE);

    // Purpose: pick the destination sector; without extension it is 0.
    generate
        if (HAS_EXT) begin : g_ext
            assign sec_sel = cmd_ext ? cmd_sector : '0;
        end else begin : g_noext
            assign sec_sel = '0;
        end
    endgenerate

    // Purpose: state register for the idle / fetch / write sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (cmd_valid) state <= ST_FETCH;
                ST_FETCH: state <= ST_WRITE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: capture the command operands when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dest_q <= '0;
            sec_q  <= '0;
        end else if (accept) begin
            addr_q <= fetch_addr;
            dest_q <= cmd_dest;
            sec_q  <= sec_sel;
        end
    end

    // Purpose: decode outputs from the current state.
    always_comb begin
        busy     = (state != ST_IDLE);
        rom_en   = (state == ST_FETCH);
        rom_addr = addr_q;
        dm_we    = (state == ST_WRITE);
        hi_we    = (state == ST_WRITE);
        dm_addr  = {sec_q, dest_q};
        dm_wdata = rom_data[LO_W-1:0];
        hi_data  = rom_data[DATA_W-1:LO_W];
    end

    AST_FETCH_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |=> (dm_we && !rom_en))
        else $error("write did not follow fetch"); // R7

    AST_WRITE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |=> (!busy && !dm_we))
        else $error("busy lasted beyond two cycles"); // R7

    AST_ACCEPT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rom_en && busy))
        else $error("accepted command did not fetch"); // R7

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !rom_en || $past(state == ST_IDLE))
        else $error("command accepted while busy"); // R9

endmodule

// File: rtl/tblrd_unit.sv
// Module: tblrd_unit (top)
// Program memory table read unit: pointer registers, address former and
// two-cycle sequencer. The low byte goes to data memory, the high byte to
// a core-readable latch.
// Assumes a synchronous ROM with one cycle of read latency.
module tblrd_unit
    import tblrd_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 16,
    parameter int OFS_W   = 8,
    parameter int DEST_W  = 8,
    parameter int SEC_W   = 2,
    parameter bit HAS_EXT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_sel,
    input  logic [OFS_W-1:0]        reg_wdata,
    output logic [OFS_W-1:0]        reg_rdata,
    input  logic                    cmd_valid,
    input  logic                    cmd_last,
    input  logic                    cmd_ext,
    input  logic [SEC_W-1:0]        cmd_sector,
    input  logic [DEST_W-1:0]       cmd_dest,
    output logic                    busy,
    output logic                    rom_en,
    output logic [ADDR_W-1:0]       rom_addr,
    input  logic [DATA_W-1:0]       rom_data,
    output logic                    dm_we,
    output logic [SEC_W+DEST_W-1:0] dm_addr,
    output logic [OFS_W-1:0]        dm_wdata
);

    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int HB_W   = DATA_W - OFS_W;

    logic [OFS_W-1:0]  ptr_ofs;
    logic [PAGE_W-1:0] ptr_page;
    logic [ADDR_W-1:0] fetch_addr;
    logic              hi_we;
    logic [HB_W-1:0]   hi_data;
    logic              accept;

    tblrd_regs #(
        .OFS_W (OFS_W),
        .PAGE_W(PAGE_W),
        .HB_W  (HB_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .hi_we   (hi_we),
        .hi_data (hi_data),
        .ptr_ofs (ptr_ofs),
        .ptr_page(ptr_page),
        .rdata   (reg_rdata)
    );

    tblrd_addr #(
        .ADDR_W(ADDR_W),
        .OFS_W (OFS_W)
    ) u_addr (
        .ptr_ofs   (ptr_ofs),
        .ptr_page  (ptr_page),
        .last_page (cmd_last),
        .fetch_addr(fetch_addr)
    );

    tblrd_seq #(
        .ADDR_W (ADDR_W),
        .DEST_W (DEST_W),
        .SEC_W  (SEC_W),
        .DATA_W (DATA_W),
        .LO_W   (OFS_W),
        .HAS_EXT(HAS_EXT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ext   (cmd_ext),
        .cmd_sector(cmd_sector),
        .cmd_dest  (cmd_dest),
        .fetch_addr(fetch_addr),
        .rom_data  (rom_data),
        .busy      (busy),
        .accept    (accept),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .dm_we     (dm_we),
        .dm_addr   (dm_addr),
        .dm_wdata  (dm_wdata),
        .hi_we     (hi_we),
        .hi_data   (hi_data)
    );

    AST_LAST_PAGE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_last) |=> (rom_addr[ADDR_W-1:OFS_W] == {PAGE_W{1'b1}}))
        else $error("final-page read left last page"); // R3

    AST_BASIC_SECTOR0: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_ext) |=> ##1 (dm_we && dm_addr[SEC_W+DEST_W-1:DEST_W] == '0))
        else $error("basic command wrote nonzero sector"); // R8

endmodule

// File: tb/tblrd_unit_bench.sv
module tblrd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        cmd_valid;
    logic        cmd_last;
    logic        cmd_ext;
    logic [1:0]  cmd_sector;
    logic [7:0]  cmd_dest;
    logic        busy;
    logic        rom_en;
    logic [12:0] rom_addr;
    logic [15:0] rom_data;
    logic        dm_we;
    logic [9:0]  dm_addr;
    logic [7:0]  dm_wdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tblrd_unit u_tblrd_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_last(cmd_last), .cmd_ext(cmd_ext), .cmd_sector(cmd_sector),
        .cmd_dest(cmd_dest), .busy(busy), .rom_en(rom_en), .rom_addr(rom_addr),
        .rom_data(rom_data), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
    );

    // ROM contents computed from the address; 0x1F06 holds 0x0042.
    function automatic logic [15:0] rom_word(input logic [12:0] a);
        logic [31:0] t;
        if (a == 13'h1F06) return 16'h0042;
        t = {19'd0, a} * 32'h9E37 ^ 32'hA5C3;
        return t[15:0] | 16'h0100;
    endfunction

    function automatic logic [12:0] exp_addr(input logic last, input logic [7:0] ofs,
                                             input logic [4:0] pg);
        return last ? {5'h1F, ofs} : {pg, ofs};
    endfunction

    // Synchronous ROM model with one cycle of latency.
    always_ff @(posedge clk) if (rom_en) rom_data <= rom_word(rom_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    // Runs one read; inject=1 drives a command and a pointer write while busy.
    task automatic do_read(input logic last, input logic ext, input logic [1:0] sec,
                           input logic [7:0] dest, input logic [7:0] ofs,
                           input logic [4:0] pg, input bit inject);
        logic [12:0] ea;
        logic [15:0] w;
        logic [7:0]  rd;
        ea = exp_addr(last, ofs, pg);
        w  = rom_word(ea);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_last = last; cmd_ext = ext;
        cmd_sector = sec; cmd_dest = dest;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R7 busy in fetch", busy, 1);
        check("R7 rom_en in fetch", rom_en, 1);
        check(last ? "R3 final-page addr" : "R2 regular addr", rom_addr, ea);
        if (inject) begin
            cmd_valid = 1'b1; cmd_last = ~last; cmd_dest = ~dest;
            reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = ~ofs;
        end
        @(negedge clk);
        check("R7 busy in write", busy, 1);
        check("R7 dm_we in write", dm_we, 1);
        check("R4 dm_wdata", dm_wdata, w[7:0]);
        check("R4 dm dest", dm_addr[7:0], dest);
        check("R8 sector", dm_addr[9:8], ext ? sec : 2'd0);
        @(negedge clk);
        check("R9 busy low after", busy, 0);
        check("R9 no extra fetch", rom_en, 0);
        cmd_valid = 1'b0; reg_wr = 1'b0;
        rd_reg(2'd2, rd);
        check("R5 latch high byte", rd, w[15:8]);
        if (inject) begin
            rd_reg(2'd0, rd);
            check("R10 offset unchanged", rd, ofs);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] ofs;
        logic [4:0] pg;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 8'd0;
        cmd_valid = 1'b0; cmd_last = 1'b0; cmd_ext = 1'b0;
        cmd_sector = 2'd0; cmd_dest = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 dm_we", dm_we, 0);
        rd_reg(2'd0, rd); check("R1 offset", rd, 0);
        rd_reg(2'd1, rd); check("R1 page", rd, 0);
        rd_reg(2'd2, rd); check("R1 latch", rd, 0);
        // R11 page masking
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, rd); check("R11 page mask", rd, 8'h1F);
        // R3 final page with offset 0x06, nonzero page
        wr_reg(2'd1, 8'h03);
        wr_reg(2'd0, 8'h06);
        wr_reg(2'd2, 8'hAA);
        do_read(1'b1, 1'b0, 2'd0, 8'h10, 8'h06, 5'h03, 1'b0);
        // R2 regular read
        do_read(1'b0, 1'b0, 2'd0, 8'h11, 8'h06, 5'h03, 1'b0);
        // R6 latch write and read back
        wr_reg(2'd2, 8'h77);
        rd_reg(2'd2, rd); check("R6 latch restore", rd, 8'h77);
        // R8 basic ignores sector, extended uses it
        do_read(1'b0, 1'b0, 2'd3, 8'h20, 8'h06, 5'h03, 1'b0);
        do_read(1'b0, 1'b1, 2'd2, 8'h21, 8'h06, 5'h03, 1'b0);
        // R9 / R10 injections during busy
        do_read(1'b0, 1'b1, 2'd1, 8'h30, 8'h06, 5'h03, 1'b1);
        do_read(1'b1, 1'b0, 2'd1, 8'h31, 8'h06, 5'h03, 1'b1);
        // Random traffic
        for (int i = 0; i < 60; i++) begin
            ofs = 8'($urandom);
            pg  = 5'($urandom);
            wr_reg(2'd0, ofs);
            wr_reg(2'd1, {3'($urandom), pg});
            if ($urandom % 3 == 0) begin
                wr_reg(2'd2, 8'($urandom));
            end
            do_read(1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom),
                    ofs, pg, ($urandom % 4) == 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule